// File: doc/BRIEF.md
# Pipelined Signed Dot-Product Unit

This unit multiplies two vectors of four signed 16-bit lanes each, lane by lane, and returns the 32-bit sum of the four products. Both operands come in as packed 64-bit words. An operation is issued by raising `in_valid` for one cycle with the two operands. The sum then appears on `result` together with a one-cycle `out_valid` pulse after a fixed number of clock edges.

A build-time switch selects one of two implementations.

- **Parallel form** (`SHARED=0`): four multipliers feed a two-level adder tree, split over three register stages. It accepts a new operation on every clock.
- **Shared form** (`SHARED=1`): a single multiplier forms one product per clock and adds it into a running sum. Four products need four clocks, so this form has a latency of four. It raises `busy` while it works and discards any request that arrives during that time.

The latency of each form is fixed by the build-time switch.

Top module: `dot4_mac`

## Requirements
- R1: While reset is held and directly after it, `out_valid` is 0, `busy` is 0 and `result` is 0.
- R2: Lane k of each operand is bits [16k+15:16k]. `result` is the sum over k of lane k of `op_a` times lane k of `op_b`.
- R3: Every lane is read as a two's-complement signed value, so negative lanes give negative products.
- R4: The sum wraps modulo 2^32 with no saturation. Four products of -32768 x -32768 give 0. Four products of -32768 x 32767 give 0x00020000.
- R5: In the parallel form, `out_valid` is high for exactly one cycle, after the third rising edge counted from the edge that captures the request.
- R6: In the parallel form, requests on consecutive cycles are all accepted. Their results come out on consecutive cycles, in issue order.
- R7: In the shared form, `out_valid` rises after the fourth rising edge counted from the capturing edge.
- R8: In the shared form, `busy` is 1 from the capturing edge until the edge that raises `out_valid`. A request made while `busy` is 1 is dropped: it produces no result and does not disturb the running sum.
- R9: `result` holds its last value in every cycle where `out_valid` is 0.
- R10: In the shared form, `busy` and `out_valid` are never 1 together. A request made in the cycle where `out_valid` is 1 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue request for the operands present this cycle |
| op_a | input | 64 | Four packed signed 16-bit lanes, first vector |
| op_b | input | 64 | Four packed signed 16-bit lanes, second vector |
| busy | output | 1 | Shared form is working and will drop requests (always 0 in parallel form) |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Wrapped sum of the four lane products |

## Verification
The lane layout is probed with operands where only one lane is nonzero. A misplaced slice or a swapped lane order then gives a visibly wrong sum. Mixed-sign lanes separate signed from unsigned multiplication. Extreme lanes built from -32768 and 32767 push the total past 32 bits and expose any saturation or lost carry. Streams of back-to-back requests, and requests raised while the shared form is still busy, separate correct pipelining and request dropping from a design that merges, reorders or restarts operations.

// File: rtl/dot4_mac.sv
module dot4_mac #(
  parameter int LW     = 16,
  parameter int OW     = 32,
  parameter bit SHARED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4*LW-1:0]   op_a,
  input  logic [4*LW-1:0]   op_b,
  output logic              busy,
  output logic              out_valid,
  output logic [OW-1:0]     result
);
  localparam int LANES = 4;
  localparam int PW    = 2 * LW;
  localparam int CW    = $clog2(LANES);

  function automatic logic signed [OW-1:0] smul(input logic [LW-1:0] x, input logic [LW-1:0] y);
    logic signed [PW-1:0] p;
    p = $signed(x) * $signed(y);
    return OW'(p);
  endfunction

  logic          busy_w, ov_w;
  logic [OW-1:0] res_w;

  generate
    if (!SHARED) begin : g_par
      logic signed [OW-1:0] prod_q [LANES];
      logic signed [OW-1:0] pair_q [2];
      logic [2:0]           vld_q;
      logic [OW-1:0]        sum_q;

      always_ff @(posedge clk) begin
        if (in_valid)
          for (int k = 0; k < LANES; k++)
            prod_q[k] <= smul(op_a[k*LW +: LW], op_b[k*LW +: LW]);
        if (vld_q[0]) begin
          pair_q[0] <= prod_q[0] + prod_q[1];
          pair_q[1] <= prod_q[2] + prod_q[3];
        end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= '0;
          sum_q <= '0;
        end else begin
          vld_q <= {vld_q[1:0], in_valid};
          if (vld_q[1]) sum_q <= pair_q[0] + pair_q[1];
        end
      end

      assign busy_w = 1'b0;
      assign ov_w   = vld_q[2];
      assign res_w  = sum_q;

      assert_lat3_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    end else begin : g_shr
      logic [4*LW-1:0]      ha_q, hb_q;
      logic [CW-1:0]        cnt_q;
      logic                 run_q, ov_q;
      logic signed [OW-1:0] acc_q;
      logic [OW-1:0]        sum_q;
      logic [4*LW-1:0]      va, vb;
      logic signed [OW-1:0] prod;

      assign va   = run_q ? ha_q : op_a;
      assign vb   = run_q ? hb_q : op_b;
      assign prod = smul(va[cnt_q*LW +: LW], vb[cnt_q*LW +: LW]);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q <= 1'b0;
          cnt_q <= '0;
          acc_q <= '0;
          sum_q <= '0;
          ov_q  <= 1'b0;
          ha_q  <= '0;
          hb_q  <= '0;
        end else begin
          ov_q <= 1'b0;
          if (!run_q && in_valid) begin
            ha_q  <= op_a;
            hb_q  <= op_b;
            acc_q <= prod;
            cnt_q <= CW'(1);
            run_q <= 1'b1;
          end else if (run_q) begin
            acc_q <= acc_q + prod;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(LANES - 1)) begin
              run_q <= 1'b0;
              cnt_q <= '0;
              sum_q <= acc_q + prod;
              ov_q  <= 1'b1;
            end
          end
        end
      end

      assign busy_w = run_q;
      assign ov_w   = ov_q;
      assign res_w  = sum_q;

      assert_lat4_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |-> ##4 out_valid);
      assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> busy);
      assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && out_valid));
      assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    end
  endgenerate

  assign busy      = busy_w;
  assign out_valid = ov_w;
  assign result    = res_w;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(result));
endmodule

// File: tb/dot4_mac_bench.sv
module dot4_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0, sv = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic        p_busy, p_ov, s_busy, s_ov;
  logic [31:0] p_res, s_res;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dot4_mac #(.SHARED(1'b0)) u_dot4_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(pv), .op_a(opa), .op_b(opb),
    .busy(p_busy), .out_valid(p_ov), .result(p_res));

  dot4_mac #(.SHARED(1'b1)) u_dot4_mac_shr (
    .clk(clk), .rst_n(rst_n), .in_valid(sv), .op_a(opa), .op_b(opb),
    .busy(s_busy), .out_valid(s_ov), .result(s_res));

  function automatic logic [31:0] ref_dot(input logic [63:0] a, input logic [63:0] b);
    logic signed [31:0] s;
    s = 0;
    for (int k = 0; k < 4; k++)
      s = s + 32'($signed(a[16*k +: 16])) * 32'($signed(b[16*k +: 16]));
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 par out_valid", 32'(p_ov), 0);
    chk("R1 par busy", 32'(p_busy), 0);
    chk("R1 par result", p_res, 0);
    chk("R1 shr out_valid", 32'(s_ov), 0);
    chk("R1 shr busy", 32'(s_busy), 0);
    chk("R1 shr result", s_res, 0);
  endtask

  task automatic t_par_one(input string tag, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] e;
    e = ref_dot(a, b);
    opa = a;
    opb = b;
    pv = 1'b1;
    tick();
    pv = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      chk({tag, " R5 par valid timing"}, 32'(p_ov), 32'(j == 3));
      if (j == 3) chk({tag, " par sum"}, p_res, e);
      if (j == 4) chk({tag, " R9 par hold"}, p_res, e);
      tick();
    end
  endtask

  task automatic t_par_stream();
    logic [63:0] aa [3], bb [3];
    logic [31:0] ee [3];
    aa[0] = 64'h0001_0002_0003_0004; bb[0] = 64'h0005_0006_0007_0008;
    aa[1] = 64'hFFFF_8000_7FFF_0010; bb[1] = 64'h0002_0003_FFFE_FFF0;
    aa[2] = 64'h1234_FEDC_0000_8001; bb[2] = 64'h00FF_0100_7777_8001;
    for (int i = 0; i < 3; i++) ee[i] = ref_dot(aa[i], bb[i]);
    for (int j = 0; j <= 6; j++) begin
      if (j >= 1) chk("R6 par stream valid", 32'(p_ov), 32'(j >= 3 && j <= 5));
      if (j >= 3 && j <= 5) chk("R6 par stream order", p_res, ee[j-3]);
      if (j == 6) chk("R9 par stream hold", p_res, ee[2]);
      if (j < 3) begin
        opa = aa[j];
        opb = bb[j];
        pv = 1'b1;
      end else pv = 1'b0;
      tick();
    end
  endtask

  task automatic t_shr_one(input string tag, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] e;
    e = ref_dot(a, b);
    opa = a;
    opb = b;
    sv = 1'b1;
    tick();
    sv = 1'b0;
    opa = '1;
    opb = '1;
    for (int j = 1; j <= 5; j++) begin
      chk({tag, " R7 shr valid timing"}, 32'(s_ov), 32'(j == 4));
      chk({tag, " R8 shr busy"}, 32'(s_busy), 32'(j <= 3));
      if (j == 4) chk({tag, " shr sum"}, s_res, e);
      if (j == 5) chk({tag, " R9 shr hold"}, s_res, e);
      tick();
    end
  endtask

  task automatic t_shr_drop();
    logic [31:0] e;
    e = ref_dot(64'h0003_FFFD_0010_0100, 64'h0004_0005_FFF0_0002);
    opa = 64'h0003_FFFD_0010_0100;
    opb = 64'h0004_0005_FFF0_0002;
    sv = 1'b1;
    tick();
    opa = 64'h7FFF_7FFF_7FFF_7FFF;
    opb = 64'h7FFF_7FFF_7FFF_7FFF;
    for (int j = 1; j <= 3; j++) tick();
    sv = 1'b0;
    chk("R8 shr drop sum", s_res, e);
    chk("R8 shr drop valid", 32'(s_ov), 1);
    for (int j = 5; j <= 9; j++) begin
      tick();
      chk("R8 shr no extra result", 32'(s_ov), 0);
      chk("R8 shr no restart", 32'(s_busy), 0);
    end
    chk("R9 shr result kept", s_res, e);
  endtask

  task automatic t_shr_b2b();
    logic [31:0] e1, e2;
    logic [63:0] a2, b2;
    a2 = 64'h0100_0200_0300_0400;
    b2 = 64'hFFFF_FFFF_FFFF_FFFF;
    e1 = ref_dot(64'h0000_0000_0000_0009, 64'h0000_0000_0000_0007);
    e2 = ref_dot(a2, b2);
    opa = 64'h0000_0000_0000_0009;
    opb = 64'h0000_0000_0000_0007;
    sv = 1'b1;
    tick();
    sv = 1'b0;
    for (int j = 1; j <= 3; j++) tick();
    chk("R10 shr first valid", 32'(s_ov), 1);
    chk("R10 shr not busy at valid", 32'(s_busy), 0);
    chk("R10 shr first sum", s_res, e1);
    opa = a2;
    opb = b2;
    sv = 1'b1;
    tick();
    sv = 1'b0;
    chk("R10 shr accepted at valid", 32'(s_busy), 1);
    for (int j = 2; j <= 4; j++) tick();
    chk("R10 shr second valid", 32'(s_ov), 1);
    chk("R10 shr second sum", s_res, e2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    // R2: single-lane probes
    t_par_one("R2 lane0", 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005);
    t_par_one("R2 lane2", 64'h0000_0011_0000_0000, 64'h0000_0002_0000_0000);
    t_par_one("R2 lane3", 64'h0007_0000_0000_0000, 64'h0009_0000_0000_0000);
    // R3: signed lanes
    t_par_one("R3 signed", 64'hFFFE_0003_FFFF_8000, 64'h0004_FFF9_FFFF_0001);
    // R4: wrap
    t_par_one("R4 wrap zero", 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000);
    chk("R4 par wrap literal", p_res, 32'h0000_0000);
    t_par_one("R4 wrap mixed", 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF);
    chk("R4 par mixed literal", p_res, 32'h0002_0000);
    t_par_stream();
    t_shr_one("R2 shr lanes", 64'h0004_0003_0002_0001, 64'h0010_0100_1000_0001);
    t_shr_one("R3 shr signed", 64'hFFFE_0003_FFFF_8000, 64'h0004_FFF9_FFFF_0001);
    t_shr_one("R4 shr wrap", 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF);
    chk("R4 shr mixed literal", s_res, 32'h0002_0000);
    t_shr_drop();
    t_shr_b2b();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule